// File: doc/BRIEF.md
# Selectable-Ratio Synchronous Clock Divider

The block derives two groups of divided clocks from a single input clock. Group A (`qa`) runs at the input rate or at half of it. Group B (`qb`) runs at one half, one third, one quarter or one sixth of the input rate. A pair of select inputs picks the combination. One input clock drives every divider stage, so every output edge the ratios have in common falls on the same rising input edge.

A falling-edge run register samples the active-low enable. Freezing and releasing therefore happen only while the input clock is low, and no shortened pulse can reach a divider. An asynchronous master reset clears every stage, which gives a known phase after power-up. Several instances can share that reset to line up with one another. A select change is applied by each group only at the end of its current output period.

Top module: `clkdiv_select`

## Requirements
- R1: With `fsel` = 0, `qa` has a period of 2 input cycles and is high for the first 1. `qb` has a period of 4 input cycles when `divsel` = 0, or 6 when `divsel` = 1. It is high for the first half of each period.
- R2: With `fsel` = 1, `qa` follows the input clock while running (divide by 1). `qb` has a period of 2 cycles (high 1, low 1) when `divsel` = 0, or 3 cycles (high 2, low 1) when `divsel` = 1.
- R3: From a reset release with the selects held steady, every rising edge of `qb` falls on a rising input edge where `qa` also rises.
- R4: While the sampled enable is inactive, `qa` and `qb` keep their levels across rising input edges. The divide-by-1 `qa` stays low during that time.
- R5: `en_n` is sampled on the falling input edge. A change made while the clock is high has no effect on the outputs until after the next falling edge.
- R6: `mr` high forces `qa` and `qb` low at once, whatever the clock and `en_n` do.
- R7: After `mr` is released, both outputs stay low until the first rising input edge that follows a falling edge where `en_n` was sampled low. On that rising edge both outputs rise together.
- R8: A change of `fsel` or `divsel` is applied by a group only when that group's current output period ends. The period in progress completes at its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock shared by all dividers |
| fsel | input | 1 | Ratio family: 0 selects /2 and /4 or /6; 1 selects /1 and /2 or /3 |
| divsel | input | 1 | Group B choice within the family: 0 for the even ratio, 1 for the larger ratio |
| en_n | input | 1 | Active-low enable, sampled on the falling clock edge |
| mr | input | 1 | Asynchronous master reset, active high |
| qa | output | 1 | Group A divided clock (/1 or /2) |
| qb | output | 1 | Group B divided clock (/2, /3, /4 or /6) |

## Verification
The assertions assume `mr` is held across at least one rising clock edge and is released while the clock is high. They also assume the selects and `en_n` never change right at a clock edge. The stimulus meets both assumptions by changing every input 2 ns after a rising edge and by holding each reset pulse for two full cycles. The random phases mix select changes, enable toggles and reset pulses. The bench's own model follows each group's period boundaries, so a select change that arrives mid-period is scored against the completed old period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Combined select code {fsel, divsel}; group B ratio is decoded from it.
    typedef enum logic [1:0] {
        SEL_SLOW_EVEN = 2'b00,
        SEL_SLOW_WIDE = 2'b01,
        SEL_FAST_EVEN = 2'b10,
        SEL_FAST_ODD  = 2'b11
    } sel_e;

endpackage

// File: rtl/clkdiv_run_gate.sv
module clkdiv_run_gate (
    input  logic clk,
    input  logic mr,
    input  logic en_n,
    output logic run
);

    logic run_d, run_q;

    always_comb begin
        run_d = ~en_n;
    end

    // Falling-edge capture: the run level can only change while clk is low.
    always_ff @(negedge clk or posedge mr) begin
        if (mr) begin
            run_q <= 1'b0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run = run_q;

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          mr,
    input  logic          adv,
    input  logic [CW-1:0] ratio_in,
    output logic          q,
    output logic [CW-1:0] ratio_cur
);

    localparam logic [CW-1:0] ONE   = 1;
    localparam logic [CW:0]   ONE_W = 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] ratio;   // zero means "not yet started since reset"
        logic          q;
    } st_t;

    st_t           st_d, st_q;
    logic          wrap;
    logic [CW:0]   hi_len;

    always_comb begin
        st_d   = st_q;
        wrap   = (st_q.ratio == '0) || (st_q.cnt == st_q.ratio - ONE);
        hi_len = '0;
        if (adv) begin
            if (wrap) begin
                st_d.ratio = ratio_in;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = st_q.cnt + ONE;
            end
            hi_len = ({1'b0, st_d.ratio} + ONE_W) >> 1;
            st_d.q = ({1'b0, st_d.cnt} < hi_len);
        end
    end

    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q         = st_q.q;
    assign ratio_cur = st_q.ratio;

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (mr)
        !adv |=> $stable(st_q)) else $error("stage moved while frozen"); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (mr)
        (st_q.ratio != '0) |-> (st_q.cnt < st_q.ratio)) else $error("count past ratio"); // R1
    AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (mr)
        !$stable(st_q.ratio) |-> (st_q.cnt == '0)) else $error("ratio changed mid-period"); // R8

endmodule

// File: rtl/clkdiv_select.sv
module clkdiv_select #(
    parameter int A_SLOW    = 2,
    parameter int B_SLOW_LO = 4,
    parameter int B_SLOW_HI = 6,
    parameter int B_FAST_LO = 2,
    parameter int B_FAST_HI = 3
) (
    input  logic clk,
    input  logic fsel,
    input  logic divsel,
    input  logic en_n,
    input  logic mr,
    output logic qa,
    output logic qb
);
    import clkdiv_pkg::*;

    localparam int MAX_AB = (A_SLOW > B_SLOW_HI) ? A_SLOW : B_SLOW_HI;
    localparam int MAX_R  = (MAX_AB > B_SLOW_LO) ? MAX_AB : B_SLOW_LO;
    localparam int CW     = $clog2(MAX_R + 1);

    localparam logic [CW-1:0] R_UNIT    = 1;
    localparam logic [CW-1:0] R_A_SLOW  = A_SLOW;
    localparam logic [CW-1:0] R_B_SL_LO = B_SLOW_LO;
    localparam logic [CW-1:0] R_B_SL_HI = B_SLOW_HI;
    localparam logic [CW-1:0] R_B_FA_LO = B_FAST_LO;
    localparam logic [CW-1:0] R_B_FA_HI = B_FAST_HI;

    logic          run;
    logic [CW-1:0] ratio_a_d, ratio_b_d;
    logic [CW-1:0] ratio_a_q, ratio_b_q;
    logic          qa_reg, qb_reg;
    logic          a_unit;

    always_comb begin
        ratio_a_d = fsel ? R_UNIT : R_A_SLOW;
        unique case (sel_e'({fsel, divsel}))
            SEL_SLOW_EVEN: ratio_b_d = R_B_SL_LO;
            SEL_SLOW_WIDE: ratio_b_d = R_B_SL_HI;
            SEL_FAST_EVEN: ratio_b_d = R_B_FA_LO;
            default:       ratio_b_d = R_B_FA_HI;
        endcase
    end

    clkdiv_run_gate u_run (
        .clk  (clk),
        .mr   (mr),
        .en_n (en_n),
        .run  (run)
    );

    clkdiv_stage #(.CW(CW)) u_grp_a (
        .clk       (clk),
        .mr        (mr),
        .adv       (run),
        .ratio_in  (ratio_a_d),
        .q         (qa_reg),
        .ratio_cur (ratio_a_q)
    );

    clkdiv_stage #(.CW(CW)) u_grp_b (
        .clk       (clk),
        .mr        (mr),
        .adv       (run),
        .ratio_in  (ratio_b_d),
        .q         (qb_reg),
        .ratio_cur (ratio_b_q)
    );

    // Divide-by-1 is the input clock ANDed with the falling-edge run level.
    assign a_unit = (ratio_a_q == R_UNIT);
    assign qa     = a_unit ? (clk & run) : qa_reg;
    assign qb     = qb_reg;

    AST_RESET_LOW: assert property (@(posedge clk)
        mr |-> (!qa && !qb)) else $error("outputs not cleared by reset"); // R6
    AST_B_RATIO_KNOWN: assert property (@(posedge clk) disable iff (mr)
        (ratio_b_q != '0) |-> (ratio_b_q == R_B_SL_LO || ratio_b_q == R_B_SL_HI ||
                               ratio_b_q == R_B_FA_LO || ratio_b_q == R_B_FA_HI))
        else $error("group B ratio outside table"); // R2

endmodule

// File: tb/clkdiv_select_bench.sv
module clkdiv_select_bench;

    logic clk = 1'b0;
    logic fsel = 1'b0, divsel = 1'b0, en_n = 1'b0, mr = 1'b1;
    logic qa, qb;

    always #10 clk = ~clk;   // 50 MHz

    clkdiv_select u_clkdiv_select (
        .clk(clk), .fsel(fsel), .divsel(divsel), .en_n(en_n), .mr(mr),
        .qa(qa), .qb(qb)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Ideal model
    bit m_run = 0;
    int a_mode = 0, a_ph = 0, a_pr = 0;
    int b_n = 0, b_ph = 0;
    bit sel_static = 0;
    int r8_win = 0;
    logic prev_qa = 0, prev_qb = 0;

    function automatic int b_ratio(logic f, logic d);
        case ({f, d})
            2'b00: return 4;
            2'b01: return 6;
            2'b10: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic exp_qa();
        if (mr) return 1'b0;
        if (a_pr != 0 && a_mode != 0) return clk & m_run;
        return (a_pr != 0 && a_ph == 0);
    endfunction

    function automatic logic exp_qb();
        if (mr || b_n == 0) return 1'b0;
        return (b_ph < (b_n + 1) / 2);
    endfunction

    function automatic string cur_tag();
        if (mr) return "R6";
        if (!m_run) return "R4";
        if (r8_win > 0) return "R8";
        return fsel ? "R2" : "R1";
    endfunction

    task automatic chk(string tag, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got=%b exp=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(posedge mr) begin
        m_run = 0;
        a_pr = 0; a_mode = 0; a_ph = 0; b_n = 0; b_ph = 0;
    end

    always @(negedge clk) m_run = mr ? 1'b0 : !en_n;

    always @(posedge clk) begin
        if (r8_win > 0) r8_win--;
        if (mr) begin
            a_pr = 0; a_mode = 0; a_ph = 0; b_n = 0; b_ph = 0;
        end else if (m_run) begin
            if (a_pr == 0 || a_mode != 0 || a_ph == 1) begin
                a_mode = fsel ? 1 : 0; a_ph = 0; a_pr = 1;
            end else a_ph = 1;
            if (b_n == 0 || b_ph == b_n - 1) begin
                b_n = b_ratio(fsel, divsel); b_ph = 0;
            end else b_ph++;
        end
    end

    // Sampling away from the edges
    always @(posedge clk) begin
        #5;
        if (!done) begin
            chk(cur_tag(), "qa(high phase)", qa, exp_qa());
            chk(cur_tag(), "qb(high phase)", qb, exp_qb());
            if (sel_static && !mr && qb === 1'b1 && prev_qb === 1'b0)   // R3 alignment
                chk("R3", "qa rises with qb", (a_mode != 0) ? qa : (qa & ~prev_qa), 1'b1);
            prev_qa = qa; prev_qb = qb;
        end
    end

    always @(negedge clk) begin
        #5;
        if (!done) begin
            chk(cur_tag(), "qa(low phase)", qa, exp_qa());
            chk(cur_tag(), "qb(low phase)", qb, exp_qb());
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic reset_pulse();
        mr = 1'b1;
        step(2);
        mr = 1'b0;
        sel_static = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        chk("R6", "qa in reset", qa, 1'b0);
        chk("R6", "qb in reset", qb, 1'b0);

        for (int c = 0; c < 4; c++) begin
            fsel = c[1]; divsel = c[0]; en_n = 1'b0;
            mr = 1'b1; step(2);
            mr = 1'b0; sel_static = 1;
            @(negedge clk); #5;
            chk("R7", "qa low before first rise", qa, 1'b0);
            chk("R7", "qb low before first rise", qb, 1'b0);
            @(posedge clk); #5;
            chk("R7", "qa first rise", qa, 1'b1);
            chk("R7", "qb first rise", qb, 1'b1);
            step(24);
            // enable dropped while clk high: still running in this high phase
            en_n = 1'b1;
            #3;
            chk("R5", "qa unchanged before falling edge", qa, exp_qa());
            step(6);
            chk("R4", "qa frozen", qa, exp_qa());
            chk("R4", "qb frozen", qb, exp_qb());
            en_n = 1'b0;
            step(13);
            mr = 1'b1; #3;
            chk("R6", "qa cleared mid-run", qa, 1'b0);
            chk("R6", "qb cleared mid-run", qb, 1'b0);
            step(2);
            mr = 1'b0;
            step(4);
        end

        // R8 directed: change ratio mid-period of group B
        fsel = 0; divsel = 0; reset_pulse();
        step(6);
        divsel = 1; sel_static = 0; r8_win = 16;
        step(20);
        fsel = 1; r8_win = 16;
        step(20);

        // Constrained random phase
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 5) begin
                fsel = $urandom_range(0, 1); divsel = $urandom_range(0, 1);
                sel_static = 0; r8_win = 8;
            end else if (r < 15) begin
                en_n = ~en_n;
            end else if (r < 17) begin
                reset_pulse();
            end
            step(1);
        end
        en_n = 1'b0;
        step(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule